// File: doc/BRIEF.md
# Peripheral Protection Controller Gate

This block sits between one bus master and up to sixteen peripheral ports and decides, for every transaction, whether it may reach the port it targets. The master supplies the target port index, the address, data, direction and two attributes: a secure bit and a privilege bit. An allowed access passes straight through, without a register stage. A blocked access never leaves the block and is answered locally in the same cycle.

Permissions come from three 16-bit configuration inputs, loaded on a single write strobe. The first gives each port a security state. The second and third are unprivileged-access enables, one for secure ports and one for non-secure ports. On every load the block recomputes one permission bit per port, choosing between the two enables according to that port's security state. A configuration bit chooses how a blocked access is answered: as a zero read with an OK response, or as a bus error. A sticky violation flag records blocked accesses and drives an interrupt.

Top module: `prot_gate`

## Requirements
- R1: After reset the latched security states and permission bits are all zero, the violation flag and interrupt are low, and no port select is driven. Every unprivileged access is therefore blocked until the first configuration load.
- R2: When `cfg_we` is high at a clock edge, each present port i latches security state `cfg_port_ns[i]` and permission bit `cfg_ns_user_en[i]` if that state is 1, or `cfg_s_user_en[i]` if it is 0. All ports are refreshed together.
- R3: Changes to `cfg_port_ns`, `cfg_s_user_en` and `cfg_ns_user_en` while `cfg_we` is low do not change which accesses are allowed.
- R4: A port whose latched security state is 1 accepts only transactions with `m_secure`=0. A port whose state is 0 accepts only transactions with `m_secure`=1.
- R5: A transaction that matches the port's security state is allowed when `m_priv`=1, and otherwise only when the port's permission bit is 1.
- R6: A port whose bit in parameter `PRESENT` is 0 blocks every access, whatever the configuration.
- R7: A blocked access returns `m_ready`=1 in the same cycle with `m_rdata` all zeros. `m_err`=0 when `cfg_err_resp`=0.
- R8: A blocked access returns `m_err`=1 when `cfg_err_resp`=1.
- R9: A blocked access, read or write, drives no bit of `p_sel` and keeps `p_write` low.
- R10: An allowed access to port k drives only `p_sel[k]`, passes `m_write`, `m_addr` and `m_wdata` unchanged, and returns that port's `p_rdata` slice (bits k*DW upward), `p_ready[k]` and `p_err[k]` to the master in the same cycle.
- R11: Any blocked access sets `viol_flag` from the next clock edge. The flag stays set until a cycle with `viol_clr` high and no blocked access. A blocked access in the same cycle as `viol_clr` leaves the flag set.
- R12: `irq` is high exactly when `viol_flag` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the three permission vectors |
| cfg_port_ns | input | NPORT | Per-port security state (1 = non-secure) |
| cfg_s_user_en | input | NPORT | Unprivileged enable used by secure ports |
| cfg_ns_user_en | input | NPORT | Unprivileged enable used by non-secure ports |
| cfg_err_resp | input | 1 | 1 = answer blocked accesses with an error |
| irq_en | input | 1 | Interrupt enable |
| viol_clr | input | 1 | Clears the violation flag |
| m_sel | input | 1 | Master request valid |
| m_port | input | PW | Target port index |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | AW | Address within the port |
| m_wdata | input | DW | Write data |
| m_secure | input | 1 | Transaction secure attribute |
| m_priv | input | 1 | Transaction privilege attribute |
| m_rdata | output | DW | Read data to master |
| m_ready | output | 1 | Response valid to master |
| m_err | output | 1 | Error response to master |
| p_sel | output | NPORT | One-hot port select |
| p_write | output | 1 | Write strobe to ports |
| p_addr | output | AW | Address to ports |
| p_wdata | output | DW | Write data to ports |
| p_rdata | input | NPORT*DW | Concatenated port read data |
| p_ready | input | NPORT | Per-port response valid |
| p_err | input | NPORT | Per-port error response |
| viol_flag | output | 1 | Sticky violation flag |
| irq | output | 1 | Violation interrupt |

## Verification
The assertions check the local answer to a blocked access on every cycle: zero data, the error bit following `cfg_err_resp`, no select and no write strobe. They also check that at most one port is selected, that allowed traffic passes address and data unchanged, that absent ports are never selected, and that the violation flag and interrupt behave as stated. What no per-cycle property can show is whether each decision is the right one. That takes the bench's sweeps, which compare every port, attribute pair and direction against a model of the latched configuration. The same sweeps show that configuration inputs moved without a load strobe are ignored, and that the error and zero-read response modes differ only where they should.

// File: rtl/ppc_gate_pkg.sv
`timescale 1ns/1ps
package ppc_gate_pkg;
  localparam int unsigned MAX_PORTS = 16;

  // Per-port permission source: non-secure ports use the non-secure
  // unprivileged enable, secure ports use the secure one.
  function automatic logic pick_perm(input logic port_ns,
                                     input logic ns_user,
                                     input logic s_user);
    return port_ns ? ns_user : s_user;
  endfunction
endpackage

// File: rtl/ppc_rst_sync.sv
`timescale 1ns/1ps
module ppc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ppc_perm_bank.sv
`timescale 1ns/1ps
module ppc_perm_bank
  import ppc_gate_pkg::*;
#(
  parameter int unsigned       NPORT   = 16,
  parameter logic [NPORT-1:0]  PRESENT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [NPORT-1:0] ns_in,
  input  logic [NPORT-1:0] s_user_in,
  input  logic [NPORT-1:0] ns_user_in,
  output logic [NPORT-1:0] ns_q,
  output logic [NPORT-1:0] ap_q
);
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    if (PRESENT[g]) begin : g_live
      logic ns_d, ap_d, ns_r, ap_r;

      always_comb begin
        ns_d = ns_in[g];
        ap_d = pick_perm(ns_in[g], ns_user_in[g], s_user_in[g]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ns_r <= 1'b0;
          ap_r <= 1'b0;
        end else if (cfg_we) begin
          ns_r <= ns_d;
          ap_r <= ap_d;
        end
      end

      assign ns_q[g] = ns_r;
      assign ap_q[g] = ap_r;
    end else begin : g_absent
      assign ns_q[g] = 1'b0;
      assign ap_q[g] = 1'b0;
    end
  end
endmodule

// File: rtl/ppc_decide.sv
`timescale 1ns/1ps
module ppc_decide #(
  parameter int unsigned       NPORT   = 16,
  parameter int unsigned       PW      = 4,
  parameter logic [NPORT-1:0]  PRESENT = '1
) (
  input  logic [PW-1:0]    m_port,
  input  logic             m_secure,
  input  logic             m_priv,
  input  logic [NPORT-1:0] ns_q,
  input  logic [NPORT-1:0] ap_q,
  output logic             allow
);
  logic [NPORT-1:0] allow_vec;

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    if (PRESENT[g]) begin : g_live
      assign allow_vec[g] = (m_secure ^ ns_q[g]) & (m_priv | ap_q[g]);
    end else begin : g_absent
      assign allow_vec[g] = 1'b0;
    end
  end

  always_comb begin
    allow = 1'b0;
    if (32'(m_port) < NPORT) allow = allow_vec[m_port];
  end
endmodule

// File: rtl/ppc_route.sv
`timescale 1ns/1ps
module ppc_route #(
  parameter int unsigned NPORT = 16,
  parameter int unsigned PW    = 4,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32
) (
  input  logic                m_sel,
  input  logic                allow,
  input  logic [PW-1:0]       m_port,
  input  logic                m_write,
  input  logic [AW-1:0]       m_addr,
  input  logic [DW-1:0]       m_wdata,
  input  logic                cfg_err_resp,
  output logic [DW-1:0]       m_rdata,
  output logic                m_ready,
  output logic                m_err,
  output logic [NPORT-1:0]    p_sel,
  output logic                p_write,
  output logic [AW-1:0]       p_addr,
  output logic [DW-1:0]       p_wdata,
  input  logic [NPORT*DW-1:0] p_rdata,
  input  logic [NPORT-1:0]    p_ready,
  input  logic [NPORT-1:0]    p_err,
  output logic                blocked
);
  assign p_addr  = m_addr;
  assign p_wdata = m_wdata;
  assign blocked = m_sel & ~allow;

  always_comb begin
    p_sel   = '0;
    p_write = 1'b0;
    m_rdata = '0;
    m_ready = 1'b0;
    m_err   = 1'b0;
    if (m_sel) begin
      if (allow) begin
        p_sel[m_port] = 1'b1;
        p_write       = m_write;
        m_rdata       = p_rdata[32'(m_port)*DW +: DW];
        m_ready       = p_ready[m_port];
        m_err         = p_err[m_port];
      end else begin
        m_ready = 1'b1;
        m_err   = cfg_err_resp;
      end
    end
  end
endmodule

// File: rtl/ppc_viol.sv
`timescale 1ns/1ps
module ppc_viol (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en;
endmodule

// File: rtl/prot_gate.sv
`timescale 1ns/1ps
module prot_gate #(
  parameter int unsigned      NPORT   = 16,
  parameter int unsigned      AW      = 12,
  parameter int unsigned      DW      = 32,
  parameter logic [NPORT-1:0] PRESENT = 16'h7DFF,
  localparam int unsigned     PW      = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [NPORT-1:0]    cfg_port_ns,
  input  logic [NPORT-1:0]    cfg_s_user_en,
  input  logic [NPORT-1:0]    cfg_ns_user_en,
  input  logic                cfg_err_resp,
  input  logic                irq_en,
  input  logic                viol_clr,
  input  logic                m_sel,
  input  logic [PW-1:0]       m_port,
  input  logic                m_write,
  input  logic [AW-1:0]       m_addr,
  input  logic [DW-1:0]       m_wdata,
  input  logic                m_secure,
  input  logic                m_priv,
  output logic [DW-1:0]       m_rdata,
  output logic                m_ready,
  output logic                m_err,
  output logic [NPORT-1:0]    p_sel,
  output logic                p_write,
  output logic [AW-1:0]       p_addr,
  output logic [DW-1:0]       p_wdata,
  input  logic [NPORT*DW-1:0] p_rdata,
  input  logic [NPORT-1:0]    p_ready,
  input  logic [NPORT-1:0]    p_err,
  output logic                viol_flag,
  output logic                irq
);
  logic             rst_n_s;
  logic [NPORT-1:0] ns_q, ap_q;
  logic             allow, blocked;

  ppc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  ppc_perm_bank #(.NPORT(NPORT), .PRESENT(PRESENT)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we),
    .ns_in(cfg_port_ns), .s_user_in(cfg_s_user_en), .ns_user_in(cfg_ns_user_en),
    .ns_q(ns_q), .ap_q(ap_q)
  );

  ppc_decide #(.NPORT(NPORT), .PW(PW), .PRESENT(PRESENT)) u_dec (
    .m_port(m_port), .m_secure(m_secure), .m_priv(m_priv),
    .ns_q(ns_q), .ap_q(ap_q), .allow(allow)
  );

  ppc_route #(.NPORT(NPORT), .PW(PW), .AW(AW), .DW(DW)) u_route (
    .m_sel(m_sel), .allow(allow), .m_port(m_port), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .cfg_err_resp(cfg_err_resp),
    .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
    .p_sel(p_sel), .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_rdata(p_rdata), .p_ready(p_ready), .p_err(p_err), .blocked(blocked)
  );

  ppc_viol u_viol (
    .clk(clk), .rst_n(rst_n_s), .set_i(blocked), .clr_i(viol_clr),
    .irq_en(irq_en), .flag_o(viol_flag), .irq_o(irq)
  );
endmodule

// File: rtl/ppc_gate_chk.sv
`timescale 1ns/1ps
module ppc_gate_chk #(
  parameter int unsigned      NPORT   = 16,
  parameter int unsigned      AW      = 12,
  parameter int unsigned      DW      = 32,
  parameter logic [NPORT-1:0] PRESENT = '1,
  parameter int unsigned      PW      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_err_resp,
  input logic             irq_en,
  input logic             viol_clr,
  input logic             m_sel,
  input logic [PW-1:0]    m_port,
  input logic             m_write,
  input logic [AW-1:0]    m_addr,
  input logic [DW-1:0]    m_wdata,
  input logic [DW-1:0]    m_rdata,
  input logic             m_ready,
  input logic             m_err,
  input logic [NPORT-1:0] p_sel,
  input logic             p_write,
  input logic [AW-1:0]    p_addr,
  input logic [DW-1:0]    p_wdata,
  input logic             viol_flag,
  input logic             irq
);
  assert_blocked_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && p_sel == '0) |-> (m_ready && m_rdata == '0));

  assert_blocked_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && p_sel == '0) |-> (m_err == cfg_err_resp));

  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p_write |-> (m_write && (p_sel != '0)));

  assert_absent_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && !PRESENT[m_port]) |-> (p_sel == '0));

  assert_onehot_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_sel));

  assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (p_sel != '0) |-> (m_sel && p_sel[m_port] && p_addr == m_addr && p_wdata == m_wdata));

  assert_viol_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && p_sel == '0) |=> viol_flag);

  assert_viol_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag);

  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && viol_flag));
endmodule

bind prot_gate ppc_gate_chk #(
  .NPORT(NPORT), .AW(AW), .DW(DW), .PRESENT(PRESENT), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_err_resp(cfg_err_resp), .irq_en(irq_en),
  .viol_clr(viol_clr), .m_sel(m_sel), .m_port(m_port), .m_write(m_write),
  .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
  .m_err(m_err), .p_sel(p_sel), .p_write(p_write), .p_addr(p_addr),
  .p_wdata(p_wdata), .viol_flag(viol_flag), .irq(irq)
);

// File: tb/sim_prot_gate.sv
`timescale 1ns/1ps
module sim_prot_gate;
  localparam int unsigned NP = 16;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam logic [NP-1:0] PRES = 16'h7DFF;
  localparam logic [NP-1:0] ERRPORTS = 16'h0020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [NP-1:0] cfg_port_ns = '0, cfg_s_user_en = '0, cfg_ns_user_en = '0;
  logic cfg_err_resp = 1'b0, irq_en = 1'b0, viol_clr = 1'b0;
  logic m_sel = 1'b0, m_write = 1'b0, m_secure = 1'b0, m_priv = 1'b0;
  logic [3:0] m_port = '0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [DW-1:0] m_rdata;
  logic m_ready, m_err;
  logic [NP-1:0] p_sel;
  logic p_write;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  logic [NP*DW-1:0] p_rdata;
  logic [NP-1:0] p_ready = '1;
  logic [NP-1:0] p_err = ERRPORTS;
  logic viol_flag, irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [NP-1:0] mod_ns = '0, mod_ap = '0;
  bit exp_viol = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] port_data(int k);
    return 32'hC0DE_0000 | (32'(k) << 8) | 32'(k * 3 + 1);
  endfunction

  for (genvar k = 0; k < NP; k++) begin : g_pd
    assign p_rdata[k*DW +: DW] = port_data(k);
  end

  prot_gate #(.NPORT(NP), .AW(AW), .DW(DW), .PRESENT(PRES)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port_ns(cfg_port_ns),
    .cfg_s_user_en(cfg_s_user_en), .cfg_ns_user_en(cfg_ns_user_en),
    .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .viol_clr(viol_clr),
    .m_sel(m_sel), .m_port(m_port), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_secure(m_secure), .m_priv(m_priv),
    .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err), .p_sel(p_sel),
    .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .p_ready(p_ready), .p_err(p_err), .viol_flag(viol_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [NP-1:0] ns, input logic [NP-1:0] su,
                          input logic [NP-1:0] nsu);
    @(negedge clk);
    cfg_port_ns = ns; cfg_s_user_en = su; cfg_ns_user_en = nsu; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int k = 0; k < NP; k++) begin
      mod_ns[k] = PRES[k] & ns[k];
      mod_ap[k] = PRES[k] & (ns[k] ? nsu[k] : su[k]);
    end
  endtask

  task automatic clear_viol();
    @(negedge clk);
    m_sel = 1'b0; viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    exp_viol = 0;
    #1;
    chk(viol_flag == 1'b0, "R11 clear", 32'(viol_flag), 32'h0);
  endtask

  task automatic one_access(input int k, input bit sec, input bit priv, input bit wr);
    bit alw;
    string why;
    logic [NP-1:0] exp_sel;
    @(negedge clk);
    m_sel = 1'b1; m_port = 4'(k); m_secure = sec; m_priv = priv; m_write = wr;
    m_addr = AW'(k * 37 + (wr ? 5 : 9));
    m_wdata = 32'h5A00_0000 ^ (32'(k) << 12) ^ 32'(sec * 2 + priv);
    #1;
    alw = PRES[k] && (sec != mod_ns[k]) && (priv || mod_ap[k]);
    if (!PRES[k]) why = "R6 absent";
    else if (sec == mod_ns[k]) why = "R4 security";
    else if (priv) why = "R5 privileged";
    else why = "R2 unprivileged";
    exp_sel = alw ? (NP'(1) << k) : '0;
    chk(p_sel == exp_sel, why, 32'(p_sel), 32'(exp_sel));
    chk(m_ready == 1'b1, "R10/R7 ready", 32'(m_ready), 32'h1);
    if (alw) begin
      chk(p_write == wr, "R10 write", 32'(p_write), 32'(wr));
      chk(p_addr == m_addr && p_wdata == m_wdata, "R10 addr/data",
          {20'h0, p_addr}, {20'h0, m_addr});
      chk(m_rdata == port_data(k), "R10 rdata", m_rdata, port_data(k));
      chk(m_err == ERRPORTS[k], "R10 err", 32'(m_err), 32'(ERRPORTS[k]));
    end else begin
      chk(p_write == 1'b0, "R9 write dropped", 32'(p_write), 32'h0);
      chk(m_rdata == '0, "R7 zero read", m_rdata, 32'h0);
      chk(m_err == cfg_err_resp, cfg_err_resp ? "R8 error" : "R7 ok resp",
          32'(m_err), 32'(cfg_err_resp));
    end
    @(posedge clk);
    #1;
    if (!alw) exp_viol = 1;
    chk(viol_flag == exp_viol, "R11 flag", 32'(viol_flag), 32'(exp_viol));
    chk(irq == (exp_viol && irq_en), "R12 irq", 32'(irq), 32'(exp_viol && irq_en));
  endtask

  task automatic sweep();
    for (int k = 0; k < NP; k++)
      for (int a = 0; a < 8; a++)
        one_access(k, a[2], a[1], a[0]);
    @(negedge clk);
    m_sel = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk(viol_flag == 1'b0 && irq == 1'b0, "R1 flag/irq", {30'h0, viol_flag, irq}, 32'h0);
    chk(p_sel == '0 && m_ready == 1'b0, "R1 idle", 32'(p_sel), 32'h0);
    // R1: unconfigured, unprivileged accesses all blocked
    irq_en = 1'b1;
    sweep();

    clear_viol();
    load_cfg(16'hA5C3, 16'h0F0F, 16'h3C3C);
    cfg_err_resp = 1'b0;
    sweep();

    // R3: inputs move without a load strobe
    clear_viol();
    @(negedge clk);
    cfg_port_ns = 16'h1234; cfg_s_user_en = 16'hFFFF; cfg_ns_user_en = 16'h0000;
    cfg_err_resp = 1'b1;
    sweep();

    clear_viol();
    irq_en = 1'b0;
    load_cfg(16'h5A3C, 16'hF0F0, 16'hC3C3);
    sweep();

    // R11: set and clear together, set wins; then clear alone
    clear_viol();
    irq_en = 1'b1;
    @(negedge clk);
    m_sel = 1'b1; m_port = 4'd9; m_secure = 1'b1; m_priv = 1'b1; viol_clr = 1'b1;
    @(posedge clk);
    #1;
    chk(viol_flag == 1'b1, "R11 set wins", 32'(viol_flag), 32'h1);
    chk(irq == 1'b1, "R12 irq on", 32'(irq), 32'h1);
    @(negedge clk);
    m_sel = 1'b0;
    @(posedge clk);
    #1;
    chk(viol_flag == 1'b0, "R11 cleared", 32'(viol_flag), 32'h0);
    viol_clr = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule